// File: doc/BRIEF.md
# Row-maskable Latin-square check-bit encoder

This block turns a data word into the parity check bits of an orthogonal Latin square (OLS) code. The data word holds M×M bits, viewed as an M-row by M-column array, with M prime. The code has 2T groups of M parity rows, so there are 2·T·M check bits and the code corrects T errors. Within each group every data bit belongs to exactly one row. Any two data bits share no more than one row across all groups. The block always computes the whole check vector. A per-row enable mask, written once the memory has been tested, then picks the rows kept for storage. A compaction stage packs the kept bits into the low end of a narrower field, and the block reports how many bits that field uses.

Data moves through a single registered stage with a valid/ready handshake on both sides. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. The enable mask is sampled at that same edge. The result appears on the next edge with `out_valid` high. It stays on the outputs until a clock edge where `out_ready` is high. When the stage is full and `out_ready` is low, `in_ready` is low. New input is therefore held back and no result is dropped. The mask is a plain control input with no handshake.

Top module: `ols_check_encoder`

## Requirements
- R1: Data bit at array row `a`, column `b` is input bit `a*M+b`. Check row `r` of group 0 is the XOR of array row `r`, that is, of bits `r*M` to `r*M+M-1`.
- R2: Check row `r` of group 1 is the XOR of array column `r`, that is, of every bit `a*M+r`.
- R3: Check row `r` of group `g` (g ≥ 2) is the XOR of every data bit whose coordinates satisfy `(a + (g-1)*b) mod M == r`. As a result, the XOR of all rows of any one group equals the XOR of the whole data word.
- R4: `check_full` puts row `r` of group `g` at bit `g*M+r`. This vector is unaffected by the enable mask.
- R5: `check_packed` holds the enabled bits of `check_full` (those whose `row_en` bit is 1) in ascending bit order, starting at bit 0. All bits above the last packed bit are 0.
- R6: `check_used` equals the number of ones in the enable mask sampled with the word.
- R7: A word accepted on an edge produces its results, with `out_valid` high, right after that edge. When no new word is accepted on an edge where `out_ready` is high, `out_valid` drops.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low. The outputs then hold their values unchanged.
- R9: `row_en` is sampled only at acceptance. Changing it while a result is held has no effect on the outputs.
- R10: After reset, `out_valid` is low, `in_ready` is high, and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Stage can take a word |
| in_data | input | M*M | Data word, bit a*M+b is array row a, column b |
| row_en | input | 2*T*M | Per-row keep mask, bit g*M+r |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| check_full | output | 2*T*M | All check bits |
| check_packed | output | 2*T*M | Enabled check bits, packed low |
| check_used | output | clog2(2*T*M+1) | Number of enabled rows |

## Verification
A wrong row membership flips a single bit of `check_full` on the first accepted word that has an odd number of ones in that row. Single-bit data words therefore expose it at once, in the cycle after acceptance. A slip in the packing order shifts or duplicates bits of `check_packed` as soon as a mask with gaps is used, and it also shows up as nonzero upper bits. A faulty handshake register shows up while a result is held: the outputs change, or `in_ready` rises, on the first stalled edge.

// File: rtl/ols_pkg.sv
package ols_pkg;
  // Row of group g that holds the data bit at array row a, column b.
  function automatic int ols_row_of(int g, int a, int b, int m);
    if (g == 0) return a;
    else if (g == 1) return b;
    else return (a + (g - 1) * b) % m;
  endfunction
endpackage

// File: rtl/ols_parity_gen.sv
module ols_parity_gen
  import ols_pkg::*;
#(
  parameter int M = 5,
  parameter int T = 2,
  localparam int D = M * M,
  localparam int G = 2 * T,
  localparam int R = G * M
) (
  input  logic [D-1:0] data_i,
  output logic [R-1:0] check_o
);
  function automatic logic [D-1:0] row_mask(int g, int r);
    logic [D-1:0] msk;
    msk = '0;
    for (int a = 0; a < M; a++)
      for (int b = 0; b < M; b++)
        if (ols_row_of(g, a, b, M) == r) msk = msk | (D'(1) << (a * M + b));
    return msk;
  endfunction

  for (genvar g = 0; g < G; g++) begin : g_grp
    for (genvar r = 0; r < M; r++) begin : g_row
      localparam logic [D-1:0] MEMBERS = row_mask(g, r);
      assign check_o[g*M+r] = ^(data_i & MEMBERS);
    end
    // R3: each group partitions the word, so its rows XOR to the word parity
    always_comb begin
      a_r3_group_parity: assert ((^check_o[g*M +: M]) == (^data_i));
    end
  end
endmodule

// File: rtl/ols_compactor.sv
module ols_compactor #(
  parameter int R  = 20,
  localparam int CW = $clog2(R + 1)
) (
  input  logic [R-1:0]  full_i,
  input  logic [R-1:0]  en_i,
  output logic [R-1:0]  packed_o,
  output logic [CW-1:0] used_o
);
  always_comb begin
    logic [R-1:0] f_sh;
    logic [R-1:0] e_sh;
    int pos;
    f_sh = full_i;
    e_sh = en_i;
    pos = 0;
    packed_o = '0;
    for (int i = 0; i < R; i++) begin
      if (e_sh[0]) begin
        packed_o = packed_o | (R'(f_sh[0]) << pos);
        pos = pos + 1;
      end
      f_sh = f_sh >> 1;
      e_sh = e_sh >> 1;
    end
    used_o = CW'(pos);
  end

  always_comb begin
    a_r6_count_matches: assert (used_o == CW'($countones(en_i)));
    a_r5_upper_zero: assert ((packed_o >> used_o) == '0);
  end
endmodule

// File: rtl/ols_check_encoder.sv
module ols_check_encoder #(
  parameter int M = 5,
  parameter int T = 2,
  localparam int D  = M * M,
  localparam int R  = 2 * T * M,
  localparam int CW = $clog2(R + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [D-1:0]  in_data,
  input  logic [R-1:0]  row_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [R-1:0]  check_full,
  output logic [R-1:0]  check_packed,
  output logic [CW-1:0] check_used
);
  logic [R-1:0]  full_c;
  logic [R-1:0]  packed_c;
  logic [CW-1:0] used_c;
  logic          accept;

  ols_parity_gen #(.M(M), .T(T)) u_parity (
    .data_i (in_data),
    .check_o(full_c)
  );

  ols_compactor #(.R(R)) u_pack (
    .full_i  (full_c),
    .en_i    (row_en),
    .packed_o(packed_c),
    .used_o  (used_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      check_full   <= '0;
      check_packed <= '0;
      check_used   <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      check_full   <= full_c;
      check_packed <= packed_c;
      check_used   <= used_c;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  a_r7_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(check_full)
      && $stable(check_packed) && $stable(check_used));

  a_r8_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/ols_check_encoder_bench.sv
`timescale 1ns/1ps
module ols_check_encoder_bench;
  localparam int M = 5, T = 2, D = M * M, R = 2 * T * M, CW = $clog2(R + 1);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [D-1:0] in_data = '0;
  logic [R-1:0] row_en = '0;
  logic in_ready, out_valid;
  logic [R-1:0] check_full, check_packed;
  logic [CW-1:0] check_used;
  int checks = 0, errors = 0;
  bit done = 0;

  ols_check_encoder #(.M(M), .T(T)) u_ols_check_encoder (.*);

  always #2.5 clk = ~clk;

  function automatic logic [R-1:0] model_full(logic [D-1:0] d);
    logic [R-1:0] e = '0;
    for (int a = 0; a < M; a++)
      for (int b = 0; b < M; b++)
        for (int g = 0; g < 2 * T; g++) begin
          int row;
          row = (g == 0) ? a : (g == 1) ? b : (a + (g - 1) * b) % M;
          e[g*M+row] ^= d[a*M+b];
        end
    return e;
  endfunction

  function automatic logic [R-1:0] model_pack(logic [R-1:0] f, logic [R-1:0] en);
    logic [R-1:0] p = '0;
    int k = 0;
    for (int i = 0; i < R; i++) if (en[i]) begin p[k] = f[i]; k++; end
    return p;
  endfunction

  function automatic int model_used(logic [R-1:0] en);
    int n = 0;
    for (int i = 0; i < R; i++) n += en[i];
    return n;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_result(string tag, logic [D-1:0] d, logic [R-1:0] en);
    logic [R-1:0] f;
    f = model_full(d);
    chk({tag, " R7 out_valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R1 R2 R3 R4 check_full"}, 64'(check_full), 64'(f));
    chk({tag, " R5 check_packed"}, 64'(check_packed), 64'(model_pack(f, en)));
    chk({tag, " R6 check_used"}, 64'(check_used), 64'(model_used(en)));
  endtask

  task automatic send(string tag, logic [D-1:0] d, logic [R-1:0] en);
    @(negedge clk);
    in_data = d; row_en = en; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check_result(tag, d, en);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [D-1:0] bd, rd;
    logic [R-1:0] ba, bb, rm;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 in_ready", 64'(in_ready), 64'd1);
    chk("R10 check_full", 64'(check_full), 64'd0);
    chk("R10 check_packed", 64'(check_packed), 64'd0);
    chk("R10 check_used", 64'(check_used), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    send("zero word", '0, '1);
    // one bit at a=2,b=3: rows g0:2, g1:3, g2:(2+3)%5=0, g3:(2+6)%5=3
    send("single bit", D'(1) << 13, '1);
    chk("R3 single bit rows", 64'(check_full), 64'((1 << 2) | (1 << 8) | (1 << 10) | (1 << 18)));
    send("all ones", '1, '1);
    send("mask empty", D'(25'h1ABCDEF), '0);
    chk("R5 empty packed zero", 64'(check_packed), 64'd0);
    send("mask alternating", D'(25'h0F0F0F3), R'(20'hAAAAA));
    send("mask top only", D'(25'h1555555), R'(1) << (R - 1));
    send("array row 4", D'(25'h1F00000), '1);
    send("array col 0", D'(25'h0108421), '1);

    // R7: idle edge with out_ready high drops out_valid
    @(negedge clk); @(posedge clk); #1;
    chk("R7 drop when idle", 64'(out_valid), 64'd0);

    // R8, R9: back-pressure hold
    @(negedge clk); out_ready = 1'b0;
    ba = R'(20'h0F3C1); bd = D'(25'h0BEEF01);
    send("stall A", bd, ba);
    @(negedge clk);
    in_data = D'(25'h1234567); row_en = R'(20'hFF00F); in_valid = 1'b1;
    #1;
    chk("R8 in_ready low", 64'(in_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check_result("R8 R9 held", bd, ba);
      @(negedge clk);
      row_en = row_en ^ R'(20'h13579);
    end
    bb = row_en;
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check_result("R8 released B", D'(25'h1234567), bb);

    for (int n = 0; n < 300; n++) begin
      rd = D'({$urandom, $urandom});
      rm = R'($urandom);
      if (n % 7 == 0) rd = D'(1) << (n % D);
      send("random", rd, rm);
    end
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule